// File: doc/BRIEF.md
# Display DMA Address and Length Counters

This block holds the two counters that drive one display DMA channel. The processor sets up a transfer in two writes over a shared data bus. One write gives the first memory address of the buffer and the other gives the number of words in it. Each write is captured by its own active-low strobe. While the memory arbiter grants the channel a cycle, the current address appears on the memory address output. At all other times that output is zero.

After each word has reached the display side, an active-low step input moves both counters together: the address goes up by one and the remaining length goes down by one. When the remaining length reaches zero, an active-low terminal-count output goes low. At the same time a sticky interrupt is raised so the processor knows the buffer has been sent. The processor clears the interrupt with an acknowledge input or by loading a new length.

All loads and steps are synchronous to `clk`. The active-low board reset is asynchronous and clears both counters and the interrupt.

Top module: `dmaCountCore`

## Requirements
- R1: While `rstN` is low, and after it is released with no other activity, the address and length counters are zero, `irq` is 0 and `termCntN` is 0.
- R2: A cycle with `addrLoadN` low sets the address counter to `dataBus[ADDR_W-1:0]` at that clock edge.
- R3: A cycle with `wordLoadN` low sets the length counter to `dataBus[WORD_W-1:0]` at that clock edge and clears `irq`.
- R4: `memAddr` equals the address counter while `grant` is 1, and is all zeros while `grant` is 0.
- R5: A cycle with `countEnN` low, a nonzero length and both load strobes high increments the address by one and decrements the length by one at the same edge.
- R6: `termCntN` is 0 exactly when the length counter is zero, and 1 otherwise.
- R7: While the length counter is zero, `countEnN` low changes neither counter.
- R8: `irq` becomes 1 at the edge where a step takes the length from 1 to 0. It then stays 1 until a cycle with `irqAck` high or a length load. If a step to zero and `irqAck` fall in the same cycle, the step wins and `irq` stays set.
- R9: If either load strobe is low in a cycle, `countEnN` is ignored in that cycle. Neither counter steps, and only the loaded counter changes.
- R10: The address counter wraps from all ones to zero on a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all loads and steps |
| rstN | input | 1 | Board reset, active low, asynchronous |
| dataBus | input | BUS_W | System data bus carrying the start address or the length |
| addrLoadN | input | 1 | Address load strobe, active low |
| wordLoadN | input | 1 | Length load strobe, active low |
| countEnN | input | 1 | Post-transfer step enable, active low |
| grant | input | 1 | Display memory grant from the arbiter |
| irqAck | input | 1 | Processor acknowledge, clears the interrupt |
| memAddr | output | ADDR_W | Current address while granted, else zero |
| termCntN | output | 1 | Terminal count, low while the length is zero |
| irq | output | 1 | Sticky transfer-complete interrupt |

## Verification
The assertions take the strobes and `countEnN` to be clean, synchronous levels. Any mix of them in one cycle is legal; the priority is defined by R9 and R8. They also take `BUS_W` to be at least as wide as both counters, so every load is exact. The stimulus changes inputs only at the falling edge. It deliberately overlaps loads with steps, acknowledges with the final step, and steps with a zero length, so that the priority rules are exercised rather than avoided.

// File: rtl/dmaCountPkg.sv
package dmaCountPkg;
  typedef struct packed {
    logic loadAddr;
    logic loadWords;
    logic step;
    logic setIrq;
    logic clrIrq;
  } dmaCtl_t;
endpackage

// File: rtl/dmaCountCtl.sv
module dmaCountCtl
  import dmaCountPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrLoadN,
  input  logic    wordLoadN,
  input  logic    countEnN,
  input  logic    irqAck,
  input  logic    wordZero,
  input  logic    wordOne,
  output dmaCtl_t ctl,
  output logic    irq
);
  logic anyLoad;

  always_comb begin
    anyLoad       = !addrLoadN || !wordLoadN;
    ctl.loadAddr  = !addrLoadN;
    ctl.loadWords = !wordLoadN;
    ctl.step      = !countEnN && !wordZero && !anyLoad;
    ctl.setIrq    = ctl.step && wordOne;
    ctl.clrIrq    = irqAck || !wordLoadN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irq <= 1'b0;
    else if (ctl.setIrq) irq <= 1'b1;
    else if (ctl.clrIrq) irq <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!countEnN && wordOne && addrLoadN && wordLoadN) |=> irq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!wordLoadN || (irqAck && !(!countEnN && wordOne))) |=> !irq); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!irqAck && wordLoadN && !ctl.setIrq) |=> $stable(irq)); // R8
endmodule

// File: rtl/dmaCountPath.sv
module dmaCountPath
  import dmaCountPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaCtl_t           ctl,
  input  logic [BUS_W-1:0]  dataBus,
  output logic [ADDR_W-1:0] addrQ,
  output logic              wordZero,
  output logic              wordOne
);
  localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(1);
  localparam logic [WORD_W-1:0] WORD_DEC = WORD_W'(1);

  logic [WORD_W-1:0] wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrQ <= '0;
    else if (ctl.loadAddr) addrQ <= dataBus[ADDR_W-1:0];
    else if (ctl.step)     addrQ <= addrQ + ADDR_INC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wordQ <= '0;
    else if (ctl.loadWords) wordQ <= dataBus[WORD_W-1:0];
    else if (ctl.step)      wordQ <= wordQ - WORD_DEC;
  end

  always_comb begin
    wordZero = (wordQ == '0);
    wordOne  = (wordQ == WORD_DEC);
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> addrQ == $past(addrQ) + ADDR_INC); // R5
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> wordQ == $past(wordQ) - WORD_DEC); // R5
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadAddr |=> addrQ == $past(dataBus[ADDR_W-1:0])); // R2
  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWords |=> wordQ == $past(dataBus[WORD_W-1:0])); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> !wordZero); // R7
endmodule

// File: rtl/dmaCountCore.sv
module dmaCountCore
  import dmaCountPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  dataBus,
  input  logic              addrLoadN,
  input  logic              wordLoadN,
  input  logic              countEnN,
  input  logic              grant,
  input  logic              irqAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic              termCntN,
  output logic              irq
);
  dmaCtl_t           ctl;
  logic [ADDR_W-1:0] addrQ;
  logic              wordZero;
  logic              wordOne;

  dmaCountCtl i_ctl (
    .clk(clk), .rstN(rstN), .addrLoadN(addrLoadN), .wordLoadN(wordLoadN),
    .countEnN(countEnN), .irqAck(irqAck), .wordZero(wordZero),
    .wordOne(wordOne), .ctl(ctl), .irq(irq)
  );

  dmaCountPath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BUS_W(BUS_W)) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataBus(dataBus),
    .addrQ(addrQ), .wordZero(wordZero), .wordOne(wordOne)
  );

  always_comb begin
    memAddr  = grant ? addrQ : '0;
    termCntN = !wordZero;
  end

  AST_ZERO_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (!termCntN && !countEnN && addrLoadN && wordLoadN)
      |=> (!termCntN && $stable(addrQ))); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!addrLoadN && wordLoadN) |=> $stable(termCntN)); // R9
endmodule

// File: tb/test_dmaCountCore.sv
module test_dmaCountCore;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int BUS_W  = 24;
  localparam int NVEC   = 13;

  // {addrLoadN, wordLoadN, countEnN, grant, irqAck, dataBus, expMemAddr, expTermCntN, expIrq}
  localparam logic [54:0] VEC [NVEC] = '{
    {5'b01110, 24'h000100, 24'h000100, 2'b00}, // R2 load address, length still zero
    {5'b10110, 24'h000003, 24'h000100, 2'b10}, // R3 load length 3
    {5'b11010, 24'h000000, 24'h000101, 2'b10}, // R5 step
    {5'b11000, 24'h000000, 24'h000000, 2'b10}, // R4 step without grant, output zero
    {5'b11010, 24'h000000, 24'h000103, 2'b01}, // R8 step to zero raises irq
    {5'b11010, 24'h000000, 24'h000103, 2'b01}, // R7 step ignored at zero
    {5'b11111, 24'h000000, 24'h000103, 2'b00}, // R8 acknowledge clears
    {5'b01110, 24'hFFFFFF, 24'hFFFFFF, 2'b00}, // R2 load top address
    {5'b10010, 24'h000002, 24'hFFFFFF, 2'b10}, // R9 length load beats step
    {5'b11010, 24'h000000, 24'h000000, 2'b10}, // R10 address wraps
    {5'b11011, 24'h000000, 24'h000001, 2'b01}, // R8 step to zero beats ack
    {5'b10110, 24'h000005, 24'h000001, 2'b10}, // R3 length load clears irq
    {5'b01010, 24'h000ABC, 24'h000ABC, 2'b10}  // R9 address load beats step
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [BUS_W-1:0]  dataBus;
  logic              addrLoadN, wordLoadN, countEnN, grant, irqAck;
  logic [ADDR_W-1:0] memAddr;
  logic              termCntN, irq;
  int checks = 0;
  int failures = 0;

  dmaCountCore #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BUS_W(BUS_W)) i_dmaCountCore (
    .clk(clk), .rstN(rstN), .dataBus(dataBus), .addrLoadN(addrLoadN),
    .wordLoadN(wordLoadN), .countEnN(countEnN), .grant(grant),
    .irqAck(irqAck), .memAddr(memAddr), .termCntN(termCntN), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle();
    addrLoadN = 1'b1; wordLoadN = 1'b1; countEnN = 1'b1;
    irqAck = 1'b0; grant = 1'b1; dataBus = '0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    chk("R1 memAddr in reset", 32'(memAddr), 32'h0);
    chk("R1 termCntN in reset", 32'(termCntN), 32'h0);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rstN = 1'b1;
    cycle();
    chk("R1 termCntN after release", 32'(termCntN), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      {addrLoadN, wordLoadN, countEnN, grant, irqAck} = VEC[i][54:50];
      dataBus = VEC[i][49:26];
      cycle();
      chk($sformatf("R4 memAddr vec %0d", i), 32'(memAddr), 32'(VEC[i][25:2]));
      chk($sformatf("R6 termCntN vec %0d", i), 32'(termCntN), 32'(VEC[i][1]));
      chk($sformatf("R8 irq vec %0d", i), 32'(irq), 32'(VEC[i][0]));
    end

    // R5/R6: length 5 from table; four steps keep termCntN high, fifth drops it
    idle();
    countEnN = 1'b0;
    for (int s = 1; s <= 5; s++) begin
      cycle();
      chk($sformatf("R5 memAddr step %0d", s), 32'(memAddr), 32'h000ABC + 32'(s));
      chk($sformatf("R6 termCntN step %0d", s), 32'(termCntN), (s == 5) ? 32'h0 : 32'h1);
    end
    chk("R8 irq at end of buffer", 32'(irq), 32'h1);
    // R7: further steps do nothing
    cycle();
    chk("R7 memAddr held at zero length", 32'(memAddr), 32'h000AC1);
    idle();

    // R1: reset in the middle of a transfer
    dataBus = 24'h000004; wordLoadN = 1'b0;
    cycle();
    idle();
    @(posedge clk);
    #1 rstN = 1'b0;
    @(negedge clk);
    chk("R1 memAddr mid reset", 32'(memAddr), 32'h0);
    chk("R1 termCntN mid reset", 32'(termCntN), 32'h0);
    chk("R1 irq mid reset", 32'(irq), 32'h0);
    rstN = 1'b1;
    cycle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule